// File: doc/BRIEF.md
# Byte-Command I/O Port Controller

This block drives an eight-pin general-purpose port from a stream of single-byte commands. Each byte arrives on a valid/ready receive interface. It is decoded into a register read, a register write, a nibble or single-bit update of the output latch, or a service action. Service actions cover a saturating glitch counter and a sequential readout of a constant identification string. A read produces one reply byte on a valid/ready transmit interface.

The output latch holds pin levels. A per-bit complement mask lets the host work in logical polarity: some writes and reads pass through an XOR with that mask, and the raw variants bypass it. A direction register marks each pin as input (1) or output (0). Commands that need a data byte park the controller in an argument state. The next received byte is then taken as data, whatever its value. While a reply waits for the transmitter, no new byte is accepted.

Top module: `bytecmd_io_port`

## Requirements
- R1: After synchronous active-low reset, pin_dir is 0xFF, pin_out is 0x00, tx_valid is 0 and rx_ready is 1.
- R2: Read codes reply with one byte: 0x00 gives pin_in XOR complement, 0x01 gives output latch XOR complement, 0x08 gives pin_in unchanged, 0x0A gives the output latch unchanged, 0x02 gives the complement mask, 0x03 gives the direction register.
- R3: Read codes 0x04, 0x05, 0x06 and 0x07 reply with the low, high, rising and falling condition masks respectively.
- R4: 0x10 loads the output latch with the complement mask; 0x11 loads it with the next byte XOR complement; 0x18 loads it with the next byte unchanged.
- R5: 0x12, 0x13, 0x14, 0x15, 0x16 and 0x17 load complement, direction, low, high, rising and falling masks from the next received byte. That byte is always treated as data, even when it equals a command code.
- R6: 0x4L sets output bits 3..0 to L XOR complement bits 3..0; 0x5H sets output bits 7..4 to H XOR complement bits 7..4; the other nibble is kept.
- R7: 0x6L writes direction bits 3..0 with L and 0x7H writes direction bits 7..4 with H, with no complement; pin_dir shows the direction register, 1 meaning input.
- R8: Commands 0x20..0x2F write one output bit: bits 2..0 give the bit index and bit 3 the new value; the other bits are kept.
- R9: 0x1F and 0xEE both perform a full reset: every register, the glitch counter and the identification index return to zero, then direction becomes 0xFF.
- R10: 0xFF increments the glitch counter, saturating at 255; 0xFE replies with the counter value and clears it in the same step.
- R11: 0xFC replies with the identification byte at the current index (index 0 is the leftmost character of ID_TEXT) and advances the index. Past the last character it replies 0 and the index stays. 0xFD sets the index to 0.
- R12: Codes 0x09, 0x0B..0x0F, 0x19..0x1E, 0x30..0x3F, 0x80..0xBF and 0xC0..0xFB except 0xEE produce no reply and change no register.
- R13: A reply byte stays on tx_data with tx_valid high until tx_ready is seen; while it is pending rx_ready is low and no byte is taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_valid | input | 1 | Command or data byte present |
| rx_ready | output | 1 | Controller takes the byte this cycle |
| rx_data | input | 8 | Received byte |
| tx_valid | output | 1 | Reply byte pending |
| tx_ready | input | 1 | Transmitter takes the reply |
| tx_data | output | 8 | Reply byte |
| pin_in | input | 8 | Sampled pin levels |
| pin_out | output | 8 | Output latch |
| pin_dir | output | 8 | Direction register, 1 = input |

## Verification
Two actions coincide in one clock edge. The glitch read captures the old count into the reply register while the same edge clears the counter. Likewise, an identification read captures the current character while the index advances. The bench provokes both: it issues several increments, then two glitch reads back to back, and expects the count and then zero. It also walks the string one position past its end. A stalled transmitter is overlapped with a new command to show the byte is refused until the reply has gone.

// File: rtl/bcp_pkg.sv
// Shared types for the byte-command I/O port controller.
// Assumes eight-bit command bytes; the opcode map depends on that width.
package bcp_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [4:0] {
        OP_NONE, OP_READ, OP_OUT_CM, OP_OUT_ARG_X, OP_OUT_ARG_RAW,
        OP_CM_ARG, OP_DIR_ARG, OP_LOW_ARG, OP_HIGH_ARG, OP_RISE_ARG,
        OP_FALL_ARG, OP_BIT, OP_OUT_LO, OP_OUT_HI, OP_DIR_LO, OP_DIR_HI,
        OP_RESET, OP_ID_NEXT, OP_ID_CLR, OP_GL_READ, OP_GL_INC
    } op_e;

    typedef enum logic [3:0] {
        RS_IN_X, RS_OUT_X, RS_CM, RS_DIR, RS_LOW, RS_HIGH, RS_RISE,
        RS_FALL, RS_IN_RAW, RS_OUT_RAW, RS_ID, RS_GLITCH
    } rsel_e;

    typedef struct packed {
        op_e   op;
        rsel_e rsel;
        logic  needs_arg;
        logic  has_reply;
    } dec_t;

    typedef enum logic [1:0] {ST_CMD, ST_ARG, ST_REPLY} st_e;
endpackage

// File: rtl/bcp_decode.sv
// Combinational opcode decoder: maps one command byte to an operation,
// a reply source, and whether an argument byte or a reply follows.
// Assumes the byte is only used when it is a command (not an argument).
module bcp_decode
    import bcp_pkg::*;
(
    input  logic [BYTE_W-1:0] cmd,
    output dec_t              dec
);
    // Decode the four top-level groups, then the sub-fields.
    always_comb begin
        dec = '{op: OP_NONE, rsel: RS_IN_X, needs_arg: 1'b0, has_reply: 1'b0};
        unique case (cmd[7:6])
            2'b00: begin
                unique case (cmd[5:4])
                    2'b00: begin
                        dec.op = OP_READ;
                        dec.has_reply = 1'b1;
                        case (cmd[3:0])
                            4'h0: dec.rsel = RS_IN_X;
                            4'h1: dec.rsel = RS_OUT_X;
                            4'h2: dec.rsel = RS_CM;
                            4'h3: dec.rsel = RS_DIR;
                            4'h4: dec.rsel = RS_LOW;
                            4'h5: dec.rsel = RS_HIGH;
                            4'h6: dec.rsel = RS_RISE;
                            4'h7: dec.rsel = RS_FALL;
                            4'h8: dec.rsel = RS_IN_RAW;
                            4'hA: dec.rsel = RS_OUT_RAW;
                            default: begin
                                dec.op = OP_NONE;
                                dec.has_reply = 1'b0;
                            end
                        endcase
                    end
                    2'b01: begin
                        dec.needs_arg = 1'b1;
                        case (cmd[3:0])
                            4'h0: begin dec.op = OP_OUT_CM; dec.needs_arg = 1'b0; end
                            4'h1: dec.op = OP_OUT_ARG_X;
                            4'h2: dec.op = OP_CM_ARG;
                            4'h3: dec.op = OP_DIR_ARG;
                            4'h4: dec.op = OP_LOW_ARG;
                            4'h5: dec.op = OP_HIGH_ARG;
                            4'h6: dec.op = OP_RISE_ARG;
                            4'h7: dec.op = OP_FALL_ARG;
                            4'h8: dec.op = OP_OUT_ARG_RAW;
                            4'hF: begin dec.op = OP_RESET; dec.needs_arg = 1'b0; end
                            default: dec.needs_arg = 1'b0;
                        endcase
                    end
                    2'b10: dec.op = OP_BIT;
                    default: dec.op = OP_NONE;
                endcase
            end
            2'b01: begin
                unique case (cmd[5:4])
                    2'b00: dec.op = OP_OUT_LO;
                    2'b01: dec.op = OP_OUT_HI;
                    2'b10: dec.op = OP_DIR_LO;
                    default: dec.op = OP_DIR_HI;
                endcase
            end
            2'b10: dec.op = OP_NONE;
            default: begin
                case (cmd)
                    8'hEE: dec.op = OP_RESET;
                    8'hFC: begin dec.op = OP_ID_NEXT; dec.rsel = RS_ID; dec.has_reply = 1'b1; end
                    8'hFD: dec.op = OP_ID_CLR;
                    8'hFE: begin dec.op = OP_GL_READ; dec.rsel = RS_GLITCH; dec.has_reply = 1'b1; end
                    8'hFF: dec.op = OP_GL_INC;
                    default: dec.op = OP_NONE;
                endcase
            end
        endcase
    end
endmodule

// File: rtl/bcp_port_regs.sv
// Port register file: output latch, direction, complement and the four
// condition masks. Applies one operation per enabled cycle; arg carries
// either the argument byte or, for nibble and bit writes, the command.
module bcp_port_regs
    import bcp_pkg::*;
#(
    parameter logic [BYTE_W-1:0] DIR_INIT = 8'hFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  op_e               op,
    input  logic [BYTE_W-1:0] arg,
    output logic [BYTE_W-1:0] out_q,
    output logic [BYTE_W-1:0] dir_q,
    output logic [BYTE_W-1:0] cm_q,
    output logic [BYTE_W-1:0] low_q,
    output logic [BYTE_W-1:0] high_q,
    output logic [BYTE_W-1:0] rise_q,
    output logic [BYTE_W-1:0] fall_q
);
    localparam int NW = BYTE_W / 2;

    // Register updates for every write-type operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0; dir_q <= DIR_INIT; cm_q <= '0;
            low_q <= '0; high_q <= '0; rise_q <= '0; fall_q <= '0;
        end else if (en) begin
            case (op)
                OP_OUT_CM:      out_q <= cm_q;
                OP_OUT_ARG_X:   out_q <= arg ^ cm_q;
                OP_OUT_ARG_RAW: out_q <= arg;
                OP_CM_ARG:      cm_q <= arg;
                OP_DIR_ARG:     dir_q <= arg;
                OP_LOW_ARG:     low_q <= arg;
                OP_HIGH_ARG:    high_q <= arg;
                OP_RISE_ARG:    rise_q <= arg;
                OP_FALL_ARG:    fall_q <= arg;
                OP_BIT:         out_q[arg[2:0]] <= arg[3];
                OP_OUT_LO:      out_q[NW-1:0] <= arg[NW-1:0] ^ cm_q[NW-1:0];
                OP_OUT_HI:      out_q[BYTE_W-1:NW] <= arg[NW-1:0] ^ cm_q[BYTE_W-1:NW];
                OP_DIR_LO:      dir_q[NW-1:0] <= arg[NW-1:0];
                OP_DIR_HI:      dir_q[BYTE_W-1:NW] <= arg[NW-1:0];
                OP_RESET: begin
                    out_q <= '0; dir_q <= DIR_INIT; cm_q <= '0;
                    low_q <= '0; high_q <= '0; rise_q <= '0; fall_q <= '0;
                end
                default: ;
            endcase
        end
    end

    a_r8_bit_write: assert property (@(posedge clk) disable iff (!rst_n)
        (en && op == OP_BIT) |=> (out_q[$past(arg[2:0])] == $past(arg[3])));

    a_r9_full_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (en && op == OP_RESET) |=> (dir_q == DIR_INIT && out_q == '0 && cm_q == '0));

    a_r7_dir_lo_keeps_hi: assert property (@(posedge clk) disable iff (!rst_n)
        (en && op == OP_DIR_LO) |=> $stable(dir_q[BYTE_W-1:NW]));
endmodule

// File: rtl/bcp_service.sv
// Service counters: saturating glitch counter with read-and-clear, and
// an index into a constant identification string (leftmost char first).
// Assumes the caller captures glitch_q and id_byte in the same edge.
module bcp_service
    import bcp_pkg::*;
#(
    parameter int                   ID_LEN  = 6,
    parameter logic [8*ID_LEN-1:0]  ID_TEXT = "BCIO8P"
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  op_e               op,
    output logic [BYTE_W-1:0] glitch_q,
    output logic [BYTE_W-1:0] id_byte
);
    localparam int IW = $clog2(ID_LEN + 1);
    localparam logic [BYTE_W-1:0] GL_MAX = '1;

    logic [IW-1:0] idx_q;

    // Glitch counter: saturating increment, clear on read or full reset.
    always_ff @(posedge clk) begin
        if (!rst_n) glitch_q <= '0;
        else if (en) begin
            if (op == OP_GL_INC && glitch_q != GL_MAX) glitch_q <= glitch_q + 1'b1;
            else if (op == OP_GL_READ || op == OP_RESET) glitch_q <= '0;
        end
    end

    // Identification index: advances until one past the last character.
    always_ff @(posedge clk) begin
        if (!rst_n) idx_q <= '0;
        else if (en) begin
            if (op == OP_ID_NEXT && idx_q != IW'(ID_LEN)) idx_q <= idx_q + 1'b1;
            else if (op == OP_ID_CLR || op == OP_RESET) idx_q <= '0;
        end
    end

    // Character lookup at the current index, zero past the end.
    always_comb begin
        id_byte = '0;
        for (int i = 0; i < ID_LEN; i++)
            if (idx_q == IW'(i)) id_byte = ID_TEXT[8*(ID_LEN-1-i) +: 8];
    end

    a_r10_glitch_saturates: assert property (@(posedge clk) disable iff (!rst_n)
        (en && op == OP_GL_INC && glitch_q == GL_MAX) |=> (glitch_q == GL_MAX));

    a_r10_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (en && op == OP_GL_READ) |=> (glitch_q == '0));

    a_r11_index_holds_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        (en && op == OP_ID_NEXT && idx_q == IW'(ID_LEN)) |=> (idx_q == IW'(ID_LEN)));
endmodule

// File: rtl/bytecmd_io_port.sv
// Top of the byte-command I/O port controller. Accepts one byte per
// handshake, waits for an argument byte where needed, and holds a reply
// until the transmitter takes it. Assumes pin_in is already synchronised.
module bytecmd_io_port
    import bcp_pkg::*;
#(
    parameter int                  ID_LEN  = 6,
    parameter logic [8*ID_LEN-1:0] ID_TEXT = "BCIO8P"
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    output logic              rx_ready,
    input  logic [BYTE_W-1:0] rx_data,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [BYTE_W-1:0] tx_data,
    input  logic [BYTE_W-1:0] pin_in,
    output logic [BYTE_W-1:0] pin_out,
    output logic [BYTE_W-1:0] pin_dir
);
    st_e  state;
    op_e  pend_op;
    dec_t dec;
    logic accept, apply_en;
    op_e  apply_op;
    logic [BYTE_W-1:0] reply_q, reply_d;
    logic [BYTE_W-1:0] out_q, dir_q, cm_q, low_q, high_q, rise_q, fall_q;
    logic [BYTE_W-1:0] glitch_q, id_byte;

    bcp_decode u_dec (.cmd(rx_data), .dec(dec));

    // Handshake and operation selection.
    always_comb begin
        rx_ready = (state != ST_REPLY);
        accept   = rx_valid && rx_ready;
        apply_en = accept && ((state == ST_CMD && !dec.needs_arg) || state == ST_ARG);
        apply_op = (state == ST_ARG) ? pend_op : dec.op;
    end

    bcp_port_regs u_regs (
        .clk(clk), .rst_n(rst_n), .en(apply_en), .op(apply_op), .arg(rx_data),
        .out_q(out_q), .dir_q(dir_q), .cm_q(cm_q), .low_q(low_q),
        .high_q(high_q), .rise_q(rise_q), .fall_q(fall_q)
    );

    bcp_service #(.ID_LEN(ID_LEN), .ID_TEXT(ID_TEXT)) u_svc (
        .clk(clk), .rst_n(rst_n), .en(apply_en), .op(apply_op),
        .glitch_q(glitch_q), .id_byte(id_byte)
    );

    // Reply source multiplexer.
    always_comb begin
        case (dec.rsel)
            RS_IN_X:    reply_d = pin_in ^ cm_q;
            RS_OUT_X:   reply_d = out_q ^ cm_q;
            RS_CM:      reply_d = cm_q;
            RS_DIR:     reply_d = dir_q;
            RS_LOW:     reply_d = low_q;
            RS_HIGH:    reply_d = high_q;
            RS_RISE:    reply_d = rise_q;
            RS_FALL:    reply_d = fall_q;
            RS_IN_RAW:  reply_d = pin_in;
            RS_OUT_RAW: reply_d = out_q;
            RS_ID:      reply_d = id_byte;
            RS_GLITCH:  reply_d = glitch_q;
            default:    reply_d = '0;
        endcase
    end

    // Command / argument / reply sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_CMD; pend_op <= OP_NONE; reply_q <= '0;
        end else begin
            case (state)
                ST_CMD: if (accept) begin
                    if (dec.needs_arg) begin
                        state <= ST_ARG; pend_op <= dec.op;
                    end else if (dec.has_reply) begin
                        state <= ST_REPLY; reply_q <= reply_d;
                    end
                end
                ST_ARG:   if (accept) state <= ST_CMD;
                default:  if (tx_ready) state <= ST_CMD;
            endcase
        end
    end

    assign tx_valid = (state == ST_REPLY);
    assign tx_data  = reply_q;
    assign pin_out  = out_q;
    assign pin_dir  = dir_q;

    a_r13_reply_held: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

    a_r5_arg_no_reply: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ARG && accept) |=> !tx_valid);

    a_r12_no_reply_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CMD && accept && !dec.has_reply) |=> !tx_valid);
endmodule

// File: tb/bytecmd_io_port_test.sv
module bytecmd_io_port_test;
    localparam int          ID_LEN  = 6;
    localparam logic [47:0] ID_TEXT = "BCIO8P";

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_valid = 1'b0;
    logic rx_ready;
    logic [7:0] rx_data = '0;
    logic tx_valid;
    logic tx_ready = 1'b1;
    logic [7:0] tx_data;
    logic [7:0] pin_in = '0;
    logic [7:0] pin_out, pin_dir;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #4 clk = ~clk;

    bytecmd_io_port #(.ID_LEN(ID_LEN), .ID_TEXT(ID_TEXT)) uut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_ready(rx_ready),
        .rx_data(rx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .tx_data(tx_data), .pin_in(pin_in), .pin_out(pin_out), .pin_dir(pin_dir)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard on each completed reply handshake.
    always @(negedge clk) begin
        if (rst_n && tx_valid && tx_ready) begin
            if (exp_q.size() == 0) begin
                total++; bad++;
                $display("FAIL unexpected reply actual=%h expected=none", tx_data);
            end else begin
                chk(tag_q.pop_front(), tx_data, exp_q.pop_front());
            end
        end
    end

    task automatic send(input logic [7:0] b);
        @(negedge clk);
        while (!rx_ready) @(negedge clk);
        rx_valid = 1'b1; rx_data = b;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic expect_rd(input logic [7:0] cmd, input logic [7:0] exp, input string tag);
        exp_q.push_back(exp); tag_q.push_back(tag);
        send(cmd);
    endtask

    task automatic drain();
        for (int i = 0; i < 40; i++) begin
            if (exp_q.size() == 0 && !tx_valid) break;
            @(negedge clk);
        end
        total++;
        if (exp_q.size() != 0) begin
            bad++;
            $display("FAIL R13 missing replies actual=%0d expected=0", exp_q.size());
            exp_q.delete(); tag_q.delete();
        end
    endtask

    task automatic no_reply(input logic [7:0] cmd);
        send(cmd);
        repeat (3) @(negedge clk);
        chk($sformatf("R12 no reply to %h", cmd), {7'b0, tx_valid}, 8'h00);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 pin_dir", pin_dir, 8'hFF);
        chk("R1 pin_out", pin_out, 8'h00);
        chk("R1 tx_valid", {7'b0, tx_valid}, 8'h00);
        chk("R1 rx_ready", {7'b0, rx_ready}, 8'h01);

        // R2 input reads
        pin_in = 8'hA5;
        expect_rd(8'h00, 8'hA5, "R2 in xor");
        expect_rd(8'h08, 8'hA5, "R2 in raw");
        drain();

        // R5 complement load, then R2 reads through it
        send(8'h12); send(8'h0F);
        expect_rd(8'h02, 8'h0F, "R2 R5 complement");
        expect_rd(8'h00, 8'hAA, "R2 in xor cm");
        expect_rd(8'h08, 8'hA5, "R2 in raw cm");
        drain();

        // R4 output loads
        send(8'h10);
        chk("R4 out=cm", pin_out, 8'h0F);
        expect_rd(8'h01, 8'h00, "R2 out xor");
        expect_rd(8'h0A, 8'h0F, "R2 out raw");
        drain();
        send(8'h11); send(8'h33);
        chk("R4 out arg xor", pin_out, 8'h3C);
        send(8'h18); send(8'hC3);
        chk("R4 out arg raw", pin_out, 8'hC3);

        // R6 nibble writes through complement
        send(8'h45);
        chk("R6 low nibble", pin_out, 8'hCA);
        send(8'h59);
        chk("R6 high nibble", pin_out, 8'h9A);

        // R8 single-bit writes
        send(8'h24);
        chk("R8 clear bit4", pin_out, 8'h8A);
        send(8'h2E);
        chk("R8 set bit6", pin_out, 8'hCA);
        send(8'h28);
        chk("R8 set bit0", pin_out, 8'hCB);

        // R7 direction nibbles
        send(8'h63);
        chk("R7 dir low", pin_dir, 8'hF3);
        send(8'h7A);
        chk("R7 dir high", pin_dir, 8'hA3);
        expect_rd(8'h03, 8'hA3, "R2 R7 dir read");
        drain();
        send(8'h13); send(8'h5A);
        chk("R5 dir arg", pin_dir, 8'h5A);

        // R3 / R5 condition masks
        send(8'h14); send(8'h11);
        send(8'h15); send(8'h22);
        send(8'h16); send(8'h44);
        send(8'h17); send(8'h88);
        expect_rd(8'h04, 8'h11, "R3 low");
        expect_rd(8'h05, 8'h22, "R3 high");
        expect_rd(8'h06, 8'h44, "R3 rise");
        expect_rd(8'h07, 8'h88, "R3 fall");
        drain();

        // R5 argument byte equal to a command code is data
        send(8'h14); send(8'hFF);
        expect_rd(8'h04, 8'hFF, "R5 arg is data");
        expect_rd(8'hFE, 8'h00, "R5 arg not a glitch cmd");
        drain();

        // R12 unassigned codes
        no_reply(8'h09); no_reply(8'h0B); no_reply(8'h0C); no_reply(8'h0F);
        no_reply(8'h1A); no_reply(8'h35); no_reply(8'h80); no_reply(8'hB7);
        no_reply(8'hC0); no_reply(8'hF0);
        chk("R12 out kept", pin_out, 8'hCB);
        chk("R12 dir kept", pin_dir, 8'h5A);
        expect_rd(8'h02, 8'h0F, "R12 cm kept");
        expect_rd(8'h04, 8'hFF, "R12 low kept");
        drain();

        // R10 glitch counter with read-and-clear
        repeat (3) send(8'hFF);
        expect_rd(8'hFE, 8'h03, "R10 count");
        expect_rd(8'hFE, 8'h00, "R10 cleared");
        drain();
        repeat (260) send(8'hFF);
        expect_rd(8'hFE, 8'hFF, "R10 saturate");
        drain();

        // R11 identification string
        for (int i = 0; i < ID_LEN; i++)
            expect_rd(8'hFC, ID_TEXT[8*(ID_LEN-1-i) +: 8], "R11 id char");
        expect_rd(8'hFC, 8'h00, "R11 past end");
        expect_rd(8'hFC, 8'h00, "R11 stays past end");
        send(8'hFD);
        expect_rd(8'hFC, ID_TEXT[47:40], "R11 index reset");
        drain();

        // R13 stalled transmitter
        @(posedge clk); #2 tx_ready = 1'b0;
        exp_q.push_back(8'hA5); tag_q.push_back("R13 held reply");
        send(8'h08);
        repeat (4) @(negedge clk);
        chk("R13 valid held", {7'b0, tx_valid}, 8'h01);
        chk("R13 data held", tx_data, 8'hA5);
        chk("R13 rx blocked", {7'b0, rx_ready}, 8'h00);
        rx_valid = 1'b1; rx_data = 8'h10;
        repeat (2) @(negedge clk);
        rx_valid = 1'b0;
        chk("R13 byte refused", pin_out, 8'hCB);
        @(posedge clk); #2 tx_ready = 1'b1;
        drain();

        // R9 full reset by 0x1F
        send(8'h1F);
        chk("R9 dir", pin_dir, 8'hFF);
        chk("R9 out", pin_out, 8'h00);
        expect_rd(8'h02, 8'h00, "R9 cm");
        expect_rd(8'h07, 8'h00, "R9 fall");
        expect_rd(8'hFC, ID_TEXT[47:40], "R9 id index");
        drain();
        // R9 full reset by 0xEE
        send(8'h18); send(8'h77);
        send(8'hFF);
        send(8'hEE);
        chk("R9 EE out", pin_out, 8'h00);
        expect_rd(8'hFE, 8'h00, "R9 EE glitch");
        drain();

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule